// File: doc/BRIEF.md
# Three-Level Radix Page Table Walker

This block translates a 39-bit virtual address into a 56-bit physical address by reading a three-level radix page table held in memory. A walk starts from a single `start` pulse. The pulse carries the virtual address, the physical base of the top table, the level to begin at and the access kind. The walker then issues one 8-byte read at a time on a simple request/response memory port. At each level it decides what to do from the entry it reads back. An invalid entry ends the walk. A pointer entry makes it descend one level. A leaf entry ends the walk, and the leaf may map a 4 KiB page or a larger superpage.

The access check on a leaf is done outside the block. The walker presents the leaf's flag byte and the access kind on its `chk_*` outputs, and an external combinational checker answers in the same cycle with a fail flag and an error code. When the walk finishes, the walker pulses `res_valid` once with a status code. On success it also gives the physical address, the leaf entry, the entry's own address, the level the leaf sat at, and the global flag gathered along the path. The block does no caching of translations and writes nothing back to memory.

Top module: `sv39_walker`

## Requirements
- R1: The read for level L goes to the current table base plus (virtual address bits [20+9L : 12+9L]) × 8. The first read uses `req_root` and `req_level`. `mem_addr` is held steady until the response arrives.
- R2: An entry with V=1 (bit 0) and R, W, X (bits 1, 2, 3) all 0 is a pointer. When it is found above level 0, the walk reads level L−1 next, with the base set to the entry's PPN (bits 53:10) shifted left by 12.
- R3: An entry with V=0, or with W=1 and R=0, ends the walk with status 2 (invalid).
- R4: A pointer entry found at level 0 ends the walk with status 2 (invalid).
- R5: A response with `mem_rsp_err` set ends the walk with status 1 (access fault).
- R6: `res_global` is the OR of the G bits (bit 5) of every entry read on the path, the leaf included.
- R7: A leaf at level L>0 with any of PPN bits [9L−1:0] set ends the walk with status 3 (misaligned).
- R8: A leaf that passes all checks returns status 0. The physical address is (PPN OR the low 9L bits of the virtual page number), followed by virtual address bits [11:0]. The result also carries the leaf entry, its address and its level L.
- R9: When `chk_fail` is high for a leaf, the walk ends with status 4 and `res_code` equal to `chk_code`. This check is made before the alignment check.
- R10: `busy` rises on the cycle after an accepted `start` and is low again in the cycle where `res_valid` pulses. A `start` while busy is ignored, and at most one memory read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a walk (taken only when not busy) |
| req_vaddr | input | 39 | Virtual address to translate |
| req_root | input | 56 | Physical base of the table at the start level |
| req_level | input | 2 | Level to start at |
| req_acc | input | 2 | Access kind, forwarded to the checker |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 56 | Address of the 8-byte entry being read |
| mem_rsp_valid | input | 1 | Read response strobe |
| mem_rsp_err | input | 1 | Read failed |
| mem_rsp_data | input | 64 | Entry read back |
| chk_pte | output | 8 | Flag byte of the entry under test |
| chk_acc | output | 2 | Access kind of the walk |
| chk_fail | input | 1 | Checker rejects the leaf |
| chk_code | input | 4 | Checker's error code |
| res_valid | output | 1 | Result strobe |
| res_status | output | 3 | 0 ok, 1 access, 2 invalid, 3 misaligned, 4 checker |
| res_paddr | output | 56 | Translated address |
| res_pte | output | 64 | Final entry read |
| res_pte_addr | output | 56 | Address of that entry |
| res_level | output | 2 | Level of that entry |
| res_global | output | 1 | Accumulated global flag |
| res_code | output | 4 | Checker code when status is 4 |

## Verification
The bench builds the walker with its default geometry: 9-bit table indices, 12 offset bits and three levels. With this geometry a walk can start at level 2 or at level 1. It can reach gigabyte and megabyte superpages, and it can end on a pointer at the bottom level. The responder's latency changes from walk to walk between one and three cycles. This shows that the entry address is held steady and that the fault checks are taken in the right order across varying response timing.

// File: rtl/sv39w_pkg.sv
package sv39w_pkg;
    parameter int VA_W    = 39;
    parameter int PA_W    = 56;
    parameter int OFS_W   = 12;
    parameter int IDX_W   = 9;
    parameter int PTE_W   = 64;
    parameter int PPN_W   = PA_W - OFS_W;
    parameter int PPN_LSB = 10;
    parameter int LVL_W   = 2;
    parameter int ACC_W   = 2;
    parameter int CODE_W  = 4;
    parameter int ENT_LOG = 3;
    parameter int VPN_W   = VA_W - OFS_W;

    typedef struct packed {
        logic d;
        logic a;
        logic g;
        logic u;
        logic x;
        logic w;
        logic r;
        logic v;
    } pte_flags_t;

    typedef enum logic [2:0] {
        ST_OK       = 3'd0,
        ST_ACCESS   = 3'd1,
        ST_INVALID  = 3'd2,
        ST_MISALIGN = 3'd3,
        ST_PERM     = 3'd4
    } walk_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQ,
        S_WAIT
    } walk_state_e;

    function automatic logic [PPN_W-1:0] pte_ppn(input logic [PTE_W-1:0] pte);
        return pte[PPN_LSB +: PPN_W];
    endfunction
endpackage

// File: rtl/sv39w_addr_gen.sv
module sv39w_addr_gen
    import sv39w_pkg::*;
(
    input  logic [PA_W-1:0]  base,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic [PA_W-1:0]  ent_addr
);
    localparam int PAD_W = PA_W - IDX_W - ENT_LOG;

    logic [VPN_W-1:0] vpn_sh;
    logic [IDX_W-1:0] idx;

    always_comb begin
        vpn_sh   = vaddr[VA_W-1:OFS_W] >> (int'(level) * IDX_W);
        idx      = vpn_sh[IDX_W-1:0];
        ent_addr = base + {{PAD_W{1'b0}}, idx, {ENT_LOG{1'b0}}};
    end
endmodule

// File: rtl/sv39w_pte_class.sv
module sv39w_pte_class
    import sv39w_pkg::*;
(
    input  pte_flags_t flags,
    output logic       is_invalid,
    output logic       is_pointer,
    output logic       is_global
);
    always_comb begin
        is_invalid = !flags.v || (flags.w && !flags.r);
        is_pointer = flags.v && !flags.r && !flags.w && !flags.x;
        is_global  = flags.g;
    end
endmodule

// File: rtl/sv39w_leaf.sv
module sv39w_leaf
    import sv39w_pkg::*;
(
    input  logic [PPN_W-1:0] ppn,
    input  logic [VA_W-1:0]  vaddr,
    input  logic [LVL_W-1:0] level,
    output logic             misaligned,
    output logic [PA_W-1:0]  paddr
);
    logic [PPN_W-1:0] low_mask;
    logic [PPN_W-1:0] vpn_ext;
    logic [PPN_W-1:0] merged;

    always_comb begin
        low_mask   = ~({PPN_W{1'b1}} << (int'(level) * IDX_W));
        vpn_ext    = {{(PPN_W-VPN_W){1'b0}}, vaddr[VA_W-1:OFS_W]};
        misaligned = |(ppn & low_mask);
        merged     = ppn | (vpn_ext & low_mask);
        paddr      = {merged, vaddr[OFS_W-1:0]};
    end
endmodule

// File: rtl/sv39_walker.sv
module sv39_walker
    import sv39w_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [VA_W-1:0]   req_vaddr,
    input  logic [PA_W-1:0]   req_root,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [ACC_W-1:0]  req_acc,
    output logic              busy,
    output logic              mem_req,
    output logic [PA_W-1:0]   mem_addr,
    input  logic              mem_rsp_valid,
    input  logic              mem_rsp_err,
    input  logic [PTE_W-1:0]  mem_rsp_data,
    output logic [7:0]        chk_pte,
    output logic [ACC_W-1:0]  chk_acc,
    input  logic              chk_fail,
    input  logic [CODE_W-1:0] chk_code,
    output logic              res_valid,
    output logic [2:0]        res_status,
    output logic [PA_W-1:0]   res_paddr,
    output logic [PTE_W-1:0]  res_pte,
    output logic [PA_W-1:0]   res_pte_addr,
    output logic [LVL_W-1:0]  res_level,
    output logic              res_global,
    output logic [CODE_W-1:0] res_code
);
    walk_state_e       state_q;
    logic [VA_W-1:0]   vaddr_q;
    logic [PA_W-1:0]   base_q;
    logic [LVL_W-1:0]  lvl_q;
    logic [ACC_W-1:0]  acc_q;
    logic              glob_q;

    logic              ent_invalid, ent_pointer, ent_global;
    logic              leaf_misaligned;
    logic [PA_W-1:0]   leaf_paddr;
    logic              rsp_here, descend, finish;
    walk_status_e      fin_status;
    logic              glob_next;

    sv39w_addr_gen u_addr (
        .base     (base_q),
        .vaddr    (vaddr_q),
        .level    (lvl_q),
        .ent_addr (mem_addr)
    );

    sv39w_pte_class u_class (
        .flags      (pte_flags_t'(mem_rsp_data[7:0])),
        .is_invalid (ent_invalid),
        .is_pointer (ent_pointer),
        .is_global  (ent_global)
    );

    sv39w_leaf u_leaf (
        .ppn        (pte_ppn(mem_rsp_data)),
        .vaddr      (vaddr_q),
        .level      (lvl_q),
        .misaligned (leaf_misaligned),
        .paddr      (leaf_paddr)
    );

    assign busy    = (state_q != S_IDLE);
    assign mem_req = (state_q == S_REQ);
    assign chk_pte = mem_rsp_data[7:0];
    assign chk_acc = acc_q;

    always_comb begin
        rsp_here   = (state_q == S_WAIT) && mem_rsp_valid;
        glob_next  = glob_q | ent_global;
        descend    = 1'b0;
        finish     = 1'b0;
        fin_status = ST_OK;
        if (rsp_here) begin
            finish = 1'b1;
            if (mem_rsp_err) begin
                fin_status = ST_ACCESS;
            end else if (ent_invalid) begin
                fin_status = ST_INVALID;
            end else if (ent_pointer) begin
                if (lvl_q == '0) begin
                    fin_status = ST_INVALID;
                end else begin
                    descend = 1'b1;
                    finish  = 1'b0;
                end
            end else if (chk_fail) begin
                fin_status = ST_PERM;
            end else if (leaf_misaligned) begin
                fin_status = ST_MISALIGN;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= S_IDLE;
            vaddr_q      <= '0;
            base_q       <= '0;
            lvl_q        <= '0;
            acc_q        <= '0;
            glob_q       <= 1'b0;
            res_valid    <= 1'b0;
            res_status   <= '0;
            res_paddr    <= '0;
            res_pte      <= '0;
            res_pte_addr <= '0;
            res_level    <= '0;
            res_global   <= 1'b0;
            res_code     <= '0;
        end else begin
            res_valid <= 1'b0;
            case (state_q)
                S_IDLE: begin
                    if (start) begin
                        vaddr_q <= req_vaddr;
                        base_q  <= req_root;
                        lvl_q   <= req_level;
                        acc_q   <= req_acc;
                        glob_q  <= 1'b0;
                        state_q <= S_REQ;
                    end
                end
                S_REQ: state_q <= S_WAIT;
                S_WAIT: begin
                    if (descend) begin
                        base_q  <= {pte_ppn(mem_rsp_data), {OFS_W{1'b0}}};
                        lvl_q   <= lvl_q - 1'b1;
                        glob_q  <= glob_next;
                        state_q <= S_REQ;
                    end else if (finish) begin
                        state_q      <= S_IDLE;
                        res_valid    <= 1'b1;
                        res_status   <= fin_status;
                        res_paddr    <= leaf_paddr;
                        res_pte      <= mem_rsp_data;
                        res_pte_addr <= mem_addr;
                        res_level    <= lvl_q;
                        res_global   <= glob_next;
                        res_code     <= (fin_status == ST_PERM) ? chk_code : '0;
                    end
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

    AST_RESULT_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !busy); // R10
    AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start)); // R10
    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_WAIT && !mem_rsp_valid) |=> $stable(mem_addr)); // R1
    AST_DESCENT_STEP: assert property (@(posedge clk) disable iff (rst)
        descend |=> (lvl_q == $past(lvl_q) - 2'd1) && mem_req); // R2
    AST_MISALIGN_UPPER: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_status == ST_MISALIGN) |-> res_level != '0); // R7
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_status == ST_OK) |-> res_paddr[OFS_W-1:0] == vaddr_q[OFS_W-1:0]); // R8
endmodule

// File: tb/tb_sv39_walker.sv
`timescale 1ns/1ps
module tb_sv39_walker;
    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [38:0] req_vaddr;
    logic [55:0] req_root;
    logic [1:0]  req_level;
    logic [1:0]  req_acc;
    logic        busy, mem_req;
    logic [55:0] mem_addr;
    logic        mem_rsp_valid, mem_rsp_err;
    logic [63:0] mem_rsp_data;
    logic [7:0]  chk_pte;
    logic [1:0]  chk_acc;
    logic        chk_fail;
    logic [3:0]  chk_code;
    logic        res_valid;
    logic [2:0]  res_status;
    logic [55:0] res_paddr, res_pte_addr;
    logic [63:0] res_pte;
    logic [1:0]  res_level;
    logic        res_global;
    logic [3:0]  res_code;

    always #10 clk = ~clk;

    sv39_walker dut (.*);

    int nchk = 0;
    int nbad = 0;

    logic [63:0] mem [logic [55:0]];
    bit          errset [logic [55:0]];
    logic [55:0] addr_q [$];
    int          lat = 1;
    int          rcnt = 0;
    logic [55:0] raddr;

    // expected result
    logic [2:0]  e_status;
    logic [55:0] e_paddr, e_pte_addr;
    logic [63:0] e_pte;
    logic [1:0]  e_level;
    logic        e_global;
    logic [3:0]  e_code;

    function automatic logic [3:0] perm_code(input logic [1:0] a);
        return 4'h8 | {2'b00, a};
    endfunction

    function automatic logic perm_bad(input logic [7:0] f, input logic [1:0] a);
        return (a == 2'd0 && !f[1]) || (a == 2'd1 && !f[2]) || (a == 2'd2 && !f[3]);
    endfunction

    // external checker: read needs R, write needs W, exec needs X
    always_comb begin
        chk_fail = perm_bad(chk_pte, chk_acc);
        chk_code = perm_code(chk_acc);
    end

    function automatic logic [55:0] ent_at(input logic [55:0] base, input logic [38:0] va, input int lv);
        logic [26:0] vpn;
        vpn = va[38:12];
        return base + 56'(((vpn >> (9 * lv)) & 27'h1ff) * 8);
    endfunction

    function automatic logic [63:0] mk(input logic [43:0] ppn, input logic [7:0] fl);
        return {10'd0, ppn, 2'b00, fl};
    endfunction

    task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
        nchk++;
        if (got !== exp) begin
            nbad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // behavioural reference for one walk
    task automatic model(input logic [38:0] va, input logic [55:0] root, input int lv0, input logic [1:0] acc);
        logic [55:0] base, a;
        logic [63:0] p;
        logic [43:0] ppn, mask;
        int lv;
        bit done;
        base = root; lv = lv0; e_global = 0; done = 0;
        e_code = 0; e_paddr = 0; e_pte = 0; e_pte_addr = 0; e_level = 0;
        addr_q.delete();
        while (!done) begin
            a = ent_at(base, va, lv);
            addr_q.push_back(a);
            if (errset.exists(a)) begin
                e_status = 3'd1; done = 1;
            end else begin
                p = mem.exists(a) ? mem[a] : 64'd0;
                e_global = e_global | p[5];
                if (!p[0] || (p[2] && !p[1])) begin
                    e_status = 3'd2; done = 1;
                end else if (p[3:1] == 3'b000) begin
                    if (lv == 0) begin
                        e_status = 3'd2; done = 1;
                    end else begin
                        base = {p[53:10], 12'h000};
                        lv = lv - 1;
                    end
                end else begin
                    done = 1;
                    ppn = p[53:10];
                    mask = (44'd1 << (9 * lv)) - 44'd1;
                    if (perm_bad(p[7:0], acc)) begin
                        e_status = 3'd4; e_code = perm_code(acc);
                    end else if ((ppn & mask) != 0) begin
                        e_status = 3'd3;
                    end else begin
                        e_status = 3'd0;
                        e_paddr = {ppn | ({17'd0, va[38:12]} & mask), va[11:0]};
                        e_pte = p; e_pte_addr = a; e_level = 2'(lv);
                    end
                end
            end
        end
    endtask

    // memory responder and per-request address comparison
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        mem_rsp_err   = 1'b0;
        if (rcnt == 1) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_err   = errset.exists(raddr);
            mem_rsp_data  = mem.exists(raddr) ? mem[raddr] : 64'd0;
        end
        if (rcnt > 0) rcnt--;
        if (mem_req && !rst) begin
            if (addr_q.size() == 0) begin
                check("R10 extra read", 64'(mem_addr), 64'hdead);
            end else begin
                check("R1/R2 entry address", 64'(mem_addr), 64'(addr_q.pop_front()));
            end
            raddr = mem_addr;
            rcnt  = lat;
        end
    end

    task automatic run(input string tag, input logic [38:0] va, input logic [55:0] root,
                       input int lv, input logic [1:0] acc, input int l, input bit poke);
        int cyc;
        model(va, root, lv, acc);
        lat = l;
        @(negedge clk);
        req_vaddr = va; req_root = root; req_level = 2'(lv); req_acc = acc; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check({tag, " R10 busy after start"}, 64'(busy), 64'd1);
        cyc = 0;
        while (!res_valid && cyc < 2000) begin
            if (poke && cyc == 2) begin
                start = 1'b1; req_vaddr = ~va; req_root = root + 56'h1000;
            end else begin
                start = 1'b0; req_vaddr = va; req_root = root;
            end
            @(negedge clk);
            cyc++;
            if (!res_valid) check({tag, " R10 busy held"}, 64'(busy), 64'd1);
        end
        start = 1'b0;
        if (!res_valid) begin
            nchk++; nbad++;
            $display("FAIL %s watchdog: got no result expected result", tag);
        end else begin
            check({tag, " R10 idle at result"}, 64'(busy), 64'd0);
            check({tag, " status"}, 64'(res_status), 64'(e_status));
            check({tag, " R10 all reads issued"}, 64'(addr_q.size()), 64'd0);
            if (e_status == 3'd0) begin
                check({tag, " R8 paddr"}, 64'(res_paddr), 64'(e_paddr));
                check({tag, " R8 pte"}, res_pte, e_pte);
                check({tag, " R8 pte addr"}, 64'(res_pte_addr), 64'(e_pte_addr));
                check({tag, " R8 level"}, 64'(res_level), 64'(e_level));
                check({tag, " R6 global"}, 64'(res_global), 64'(e_global));
            end
            if (e_status == 3'd4) check({tag, " R9 code"}, 64'(res_code), 64'(e_code));
        end
        @(negedge clk);
        check({tag, " R10 single pulse"}, 64'(res_valid), 64'd0);
    endtask

    initial begin
        #(20 * 200000);
        nchk++; nbad++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        logic [38:0] va;
        rst = 1'b1; start = 1'b0; req_vaddr = '0; req_root = '0; req_level = '0; req_acc = '0;
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0; mem_rsp_data = '0;
        repeat (3) @(negedge clk);
        check("R10 reset busy", 64'(busy), 64'd0);
        check("R10 reset result", 64'(res_valid), 64'd0);
        check("R10 reset request", 64'(mem_req), 64'd0);
        rst = 1'b0;

        // R2 R6 R8: three-level walk to 4 KiB page, G only on top pointer
        va = 39'h40_2030_4567;
        mem[ent_at(56'h100000, va, 2)] = mk(44'h200, 8'h21);
        mem[ent_at(56'h200000, va, 1)] = mk(44'h300, 8'h01);
        mem[ent_at(56'h300000, va, 0)] = mk(44'h12345, 8'h07);
        run("R2/R6 4K walk", va, 56'h100000, 2, 2'd1, 1, 0);
        // R10: start pulse while busy must be ignored
        run("R10 start while busy", va, 56'h100000, 2, 2'd1, 3, 1);

        // R3 V=0 at top level
        run("R3 V clear", 39'h11_1111_1000, 56'h400000, 2, 2'd0, 2, 0);
        // R3 W without R
        va = 39'h22_0000_0000;
        mem[ent_at(56'h500000, va, 2)] = mk(44'h7, 8'h05);
        run("R3 W without R", va, 56'h500000, 2, 2'd0, 1, 0);
        // R4 pointer at level 0
        va = 39'h00_0000_5000;
        mem[ent_at(56'h600000, va, 0)] = mk(44'h9, 8'h01);
        run("R4 pointer at bottom", va, 56'h600000, 0, 2'd0, 2, 0);
        // R5 error response at level 1
        va = 39'h33_4455_6000;
        mem[ent_at(56'h700000, va, 2)] = mk(44'h710, 8'h01);
        errset[ent_at(56'h710000, va, 1)] = 1'b1;
        run("R5 access fault", va, 56'h700000, 2, 2'd0, 3, 0);
        // R8 aligned 1 GiB superpage, exec access
        va = 39'h15_2345_6789;
        mem[ent_at(56'h800000, va, 2)] = mk(44'h40000, 8'h0B);
        run("R8 gig superpage", va, 56'h800000, 2, 2'd2, 1, 0);
        // R7 misaligned 2 MiB superpage
        va = 39'h01_4060_0abc;
        mem[ent_at(56'h900000, va, 2)] = mk(44'h910, 8'h01);
        mem[ent_at(56'h910000, va, 1)] = mk(44'h601, 8'h03);
        run("R7 misaligned", va, 56'h900000, 2, 2'd0, 2, 0);
        // R9 checker failure wins over misalignment (write to read-only)
        run("R9 checker before align", va, 56'h900000, 2, 2'd1, 1, 0);
        // R9 checker failure on 4 KiB leaf
        va = 39'h40_2030_4567;
        mem[ent_at(56'h300000, va, 0)] = mk(44'h12345, 8'h03);
        run("R9 checker fail", va, 56'h100000, 2, 2'd1, 2, 0);
        // R1 R8 start at level 1, aligned 2 MiB page, G on leaf
        va = 39'h00_5fe1_2345;
        mem[ent_at(56'ha00000, va, 1)] = mk(44'h800, 8'h27);
        run("R1/R6 start at level 1", va, 56'ha00000, 1, 2'd0, 3, 0);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule